// File: doc/BRIEF.md
# TDM Audio Receive Deserializer

This block turns one serial audio data line into parallel samples. Several input data lines arrive at the block and a one-hot select picks the one to capture; when the no-loopback control is cleared, the block's own transmit stream is also merged onto the capture line. The bit clock and frame sync are slow, level-type inputs in the system clock domain, and the block finds their edges itself. The same slot count, slot width, bit order, sampling edge and bit delay settings as the matching transmitter describe the frame.

Each slot is assembled bit by bit and placed at the low end of a 32-bit word, with zeros above it. A receive slot mask names the slots to drop. Among the slots that are kept, only the lowest ones up to a channel count are written into a small sample FIFO. Capture begins on the first frame sync after enable, so a partial frame is never written. A self-clearing reset request clears the FIFO, the overflow flag and the frame state, and reports busy until it has completed.

Top module: `tdm_rx_deser`

## Requirements
- R1: The captured line is the bit of `sd_i` whose position matches the single set bit of `port_sel_i`. The other data lines have no effect.
- R2: With `no_fb_i`=1 only the selected line is sampled. With `no_fb_i`=0 the sampled bit is the selected line ORed with `lpbk_i`.
- R3: `width_sel_i` 0/1/2/3 selects 16/20/24/32 bits per slot, and a frame holds `slots_m1_i`+1 slots. Bits that follow the final slot are ignored until the next frame start.
- R4: With `lsb_first_i`=0 the first bit of a slot is its MSB. With `lsb_first_i`=1 the first bit is bit 0.
- R5: With `sclk_fall_i`=0 data is sampled on rising `sclk_i`. With `sclk_fall_i`=1 it is sampled on falling `sclk_i`.
- R6: A frame starts at the sampling edge where `fsync_i` is first seen high after being low. With `bit_start_i`=0 the first data bit is taken at that edge. With `bit_start_i`=1 it is taken at the next sampling edge.
- R7: A 1 in `slot_ignore_i[s]` drops slot s. Of the slots that are not dropped and fall within the slot count, only the lowest `nchans_i` are written.
- R8: A sample sits in bits [width-1:0] of `rd_data_o`, and the upper 32-width bits are zero.
- R9: A one-cycle `rst_req_i` makes `rst_busy_o` high from the next cycle for RST_CYCLES cycles. It empties the FIFO, clears the overflow flag and stops the current frame. No capture takes place while the block is busy.
- R10: Samples leave the FIFO in arrival order through `rd_valid_o`/`rd_pop_i`. A sample that arrives while the FIFO is full is dropped and sets `overflow_o`, which stays set until a reset request.
- R11: After `enable_i` rises, capture starts at the next frame start. A frame that is already in progress is never written.
- R12: While `enable_i` is low nothing is written. A frame cut off by disable writes none of its remaining slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| enable_i | input | 1 | capture enable |
| rst_req_i | input | 1 | one-cycle self-clearing reset request |
| rst_busy_o | output | 1 | reset request in progress |
| sclk_i | input | 1 | bit clock level, synchronous to clk |
| fsync_i | input | 1 | frame sync level |
| sd_i | input | N_PORTS | serial data lines |
| lpbk_i | input | 1 | internal transmit data for loopback |
| port_sel_i | input | N_PORTS | one-hot line select |
| no_fb_i | input | 1 | 1 = block loopback data |
| slots_m1_i | input | SLOT_W | slots per frame minus one |
| width_sel_i | input | 2 | slot width code |
| lsb_first_i | input | 1 | bit order |
| sclk_fall_i | input | 1 | sample on falling bit clock |
| bit_start_i | input | 1 | one-bit data delay after frame start |
| slot_ignore_i | input | MAX_SLOTS | 1 = drop slot |
| nchans_i | input | SLOT_W+1 | channel count used to trim kept slots |
| rd_data_o | output | 32 | FIFO head sample |
| rd_valid_o | output | 1 | FIFO not empty |
| rd_pop_i | input | 1 | remove head sample |
| overflow_o | output | 1 | sticky overflow flag |

## Verification
A wrong bit or slot counter shows up at the FIFO output as soon as the next slot completes. The sample then arrives shifted, appears in the wrong order or goes missing, so the scoreboard reports it within one slot time. A fault in frame start tracking shows up as extra or missing samples around an enable edge, and the queue length at the end of each test catches it. Faults in the reset counter and the overflow flag appear at `rst_busy_o` and `overflow_o` within a few cycles of the request or of the dropped push.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
    localparam int SAMPLE_W = 32;

    typedef enum logic [1:0] {
        WID_16 = 2'd0,
        WID_20 = 2'd1,
        WID_24 = 2'd2,
        WID_32 = 2'd3
    } wid_e;

    function automatic logic [5:0] slot_bits(input logic [1:0] code);
        case (wid_e'(code))
            WID_16:  slot_bits = 6'd16;
            WID_20:  slot_bits = 6'd20;
            WID_24:  slot_bits = 6'd24;
            default: slot_bits = 6'd32;
        endcase
    endfunction
endpackage

// File: rtl/tdm_rx_line_sel.sv
module tdm_rx_line_sel #(
    parameter int N_PORTS = 4
) (
    input  logic [N_PORTS-1:0] sd_i,
    input  logic [N_PORTS-1:0] port_sel_i,
    input  logic               lpbk_i,
    input  logic               no_fb_i,
    output logic               rx_bit_o
);
    logic line_bit;

    always_comb begin
        line_bit = |(sd_i & port_sel_i);
        rx_bit_o = line_bit | (lpbk_i & ~no_fb_i);
    end
endmodule

// File: rtl/tdm_rx_slot_crop.sv
module tdm_rx_slot_crop #(
    parameter int MAX_SLOTS = 8,
    localparam int SLOT_W = $clog2(MAX_SLOTS)
) (
    input  logic [MAX_SLOTS-1:0] slot_ignore_i,
    input  logic [SLOT_W-1:0]    slots_m1_i,
    input  logic [SLOT_W:0]      nchans_i,
    output logic [MAX_SLOTS-1:0] keep_o
);
    logic [SLOT_W:0] kept;

    always_comb begin
        kept   = '0;
        keep_o = '0;
        for (int s = 0; s < MAX_SLOTS; s++) begin
            if ((s <= int'(slots_m1_i)) && !slot_ignore_i[s] && (kept < nchans_i)) begin
                keep_o[s] = 1'b1;
                kept      = kept + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdm_rx_fifo.sv
module tdm_rx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         valid_o,
    output logic         full_o
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t q, n;
    logic  do_push, do_pop;

    always_comb begin
        n       = q;
        full_o  = (q.cnt == CNT_W'(DEPTH));
        valid_o = (q.cnt != '0);
        dout_o  = q.mem[q.rd];
        do_push = push_i && !full_o;
        do_pop  = pop_i && valid_o;
        if (clear_i) begin
            n.wr  = '0;
            n.rd  = '0;
            n.cnt = '0;
        end else begin
            if (do_push) begin
                n.mem[q.wr] = din_i;
                n.wr = (q.wr == PTR_W'(DEPTH - 1)) ? '0 : q.wr + 1'b1;
            end
            if (do_pop) begin
                n.rd = (q.rd == PTR_W'(DEPTH - 1)) ? '0 : q.rd + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   n.cnt = q.cnt + 1'b1;
                2'b01:   n.cnt = q.cnt - 1'b1;
                default: n.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
    import tdm_rx_pkg::*;
#(
    parameter int N_PORTS    = 4,
    parameter int MAX_SLOTS  = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int RST_CYCLES = 3,
    localparam int SLOT_W = $clog2(MAX_SLOTS),
    localparam int BIT_W  = $clog2(SAMPLE_W),
    localparam int RC_W   = $clog2(RST_CYCLES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable_i,
    input  logic                 rst_req_i,
    output logic                 rst_busy_o,
    input  logic                 sclk_i,
    input  logic                 fsync_i,
    input  logic [N_PORTS-1:0]   sd_i,
    input  logic                 lpbk_i,
    input  logic [N_PORTS-1:0]   port_sel_i,
    input  logic                 no_fb_i,
    input  logic [SLOT_W-1:0]    slots_m1_i,
    input  logic [1:0]           width_sel_i,
    input  logic                 lsb_first_i,
    input  logic                 sclk_fall_i,
    input  logic                 bit_start_i,
    input  logic [MAX_SLOTS-1:0] slot_ignore_i,
    input  logic [SLOT_W:0]      nchans_i,
    output logic [SAMPLE_W-1:0]  rd_data_o,
    output logic                 rd_valid_o,
    input  logic                 rd_pop_i,
    output logic                 overflow_o
);
    typedef struct packed {
        logic                sclk;
        logic                fs;
        logic                active;
        logic [SLOT_W-1:0]   slot;
        logic [BIT_W-1:0]    bitc;
        logic [SAMPLE_W-1:0] sh;
        logic [RC_W-1:0]     rcnt;
        logic                ovf;
    } rx_state_t;

    rx_state_t q, n;

    logic                 rx_bit;
    logic [MAX_SLOTS-1:0] keep;
    logic                 fifo_full;
    logic                 push;
    logic [SAMPLE_W-1:0]  push_data;
    logic                 bit_edge;
    logic                 fs_rise;
    logic                 do_bit;
    logic [SLOT_W-1:0]    cs;
    logic [BIT_W-1:0]     cb;
    logic [SAMPLE_W-1:0]  cbase;
    logic [SAMPLE_W-1:0]  nsh;
    logic [BIT_W-1:0]     wlast;
    logic [5:0]           wbits;

    tdm_rx_line_sel #(.N_PORTS(N_PORTS)) i_line_sel (
        .sd_i       (sd_i),
        .port_sel_i (port_sel_i),
        .lpbk_i     (lpbk_i),
        .no_fb_i    (no_fb_i),
        .rx_bit_o   (rx_bit)
    );

    tdm_rx_slot_crop #(.MAX_SLOTS(MAX_SLOTS)) i_slot_crop (
        .slot_ignore_i (slot_ignore_i),
        .slots_m1_i    (slots_m1_i),
        .nchans_i      (nchans_i),
        .keep_o        (keep)
    );

    tdm_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(SAMPLE_W)) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (rst_req_i),
        .push_i  (push),
        .din_i   (push_data),
        .pop_i   (rd_pop_i),
        .dout_o  (rd_data_o),
        .valid_o (rd_valid_o),
        .full_o  (fifo_full)
    );

    always_comb begin
        n         = q;
        push      = 1'b0;
        push_data = '0;
        do_bit    = 1'b0;
        cs        = q.slot;
        cb        = q.bitc;
        cbase     = q.sh;
        nsh       = '0;
        wbits     = slot_bits(width_sel_i);
        wlast     = BIT_W'(wbits - 6'd1);

        n.sclk   = sclk_i;
        bit_edge = sclk_fall_i ? (q.sclk && !sclk_i) : (!q.sclk && sclk_i);
        fs_rise  = bit_edge && fsync_i && !q.fs;
        if (bit_edge) n.fs = fsync_i;

        if (rst_req_i) begin
            n.rcnt   = RC_W'(RST_CYCLES);
            n.active = 1'b0;
            n.ovf    = 1'b0;
        end else begin
            if (q.rcnt != '0) n.rcnt = q.rcnt - 1'b1;

            if (!enable_i || (q.rcnt != '0)) begin
                n.active = 1'b0;
            end else if (fs_rise) begin
                n.active = 1'b1;
                n.slot   = '0;
                n.bitc   = '0;
                n.sh     = '0;
                cs       = '0;
                cb       = '0;
                cbase    = '0;
                do_bit   = !bit_start_i;
            end else if (bit_edge && q.active) begin
                do_bit = 1'b1;
            end

            if (do_bit) begin
                if (lsb_first_i) nsh = cbase | (SAMPLE_W'(rx_bit) << cb);
                else             nsh = {cbase[SAMPLE_W-2:0], rx_bit};
                if (cb == wlast) begin
                    push      = keep[cs];
                    push_data = nsh;
                    n.sh      = '0;
                    n.bitc    = '0;
                    if (cs == slots_m1_i) n.active = 1'b0;
                    else                  n.slot   = cs + 1'b1;
                end else begin
                    n.bitc = cb + 1'b1;
                    n.sh   = nsh;
                end
            end

            if (push && fifo_full) n.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign rst_busy_o = (q.rcnt != '0);
    assign overflow_o = q.ovf;
endmodule

// File: rtl/tdm_rx_deser_chk.sv
module tdm_rx_deser_chk (
    input logic clk,
    input logic rst_n,
    input logic enable_i,
    input logic rst_req_i,
    input logic rst_busy_o,
    input logic rd_valid_o,
    input logic overflow_o
);
    // R9
    rst_req_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_i |=> (rst_busy_o && !overflow_o && !rd_valid_o));

    // R9
    busy_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_busy_o |-> !rd_valid_o);

    // R10
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !rst_req_i) |=> overflow_o);

    // R12
    disabled_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && !rd_valid_o && !rst_req_i) |=> !rd_valid_o);
endmodule

bind tdm_rx_deser tdm_rx_deser_chk i_tdm_rx_deser_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_i),
    .rst_req_i  (rst_req_i),
    .rst_busy_o (rst_busy_o),
    .rd_valid_o (rd_valid_o),
    .overflow_o (overflow_o)
);

// File: tb/test_tdm_rx_deser.sv
module test_tdm_rx_deser;
    localparam int NP = 4;
    localparam int MS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0;
    logic        rst_req_i = 1'b0;
    logic        rst_busy_o;
    logic        sclk_i = 1'b0;
    logic        fsync_i = 1'b0;
    logic [NP-1:0] sd_i = '0;
    logic        lpbk_i = 1'b0;
    logic [NP-1:0] port_sel_i = 4'b0001;
    logic        no_fb_i = 1'b1;
    logic [2:0]  slots_m1_i = 3'd1;
    logic [1:0]  width_sel_i = 2'd0;
    logic        lsb_first_i = 1'b0;
    logic        sclk_fall_i = 1'b0;
    logic        bit_start_i = 1'b1;
    logic [MS-1:0] slot_ignore_i = '0;
    logic [3:0]  nchans_i = 4'd8;
    logic [31:0] rd_data_o;
    logic        rd_valid_o;
    logic        rd_pop_i = 1'b0;
    logic        overflow_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit mon_on = 1'b1;
    int port_idx = 0;
    logic [31:0] vals [MS];
    logic [31:0] expq [$];

    always #2 clk = ~clk;

    tdm_rx_deser i_tdm_rx_deser (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .rst_req_i(rst_req_i),
        .rst_busy_o(rst_busy_o), .sclk_i(sclk_i), .fsync_i(fsync_i), .sd_i(sd_i),
        .lpbk_i(lpbk_i), .port_sel_i(port_sel_i), .no_fb_i(no_fb_i),
        .slots_m1_i(slots_m1_i), .width_sel_i(width_sel_i), .lsb_first_i(lsb_first_i),
        .sclk_fall_i(sclk_fall_i), .bit_start_i(bit_start_i),
        .slot_ignore_i(slot_ignore_i), .nchans_i(nchans_i), .rd_data_o(rd_data_o),
        .rd_valid_o(rd_valid_o), .rd_pop_i(rd_pop_i), .overflow_o(overflow_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] wmask(input int w);
        return (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    endfunction

    function automatic int wbits_of(input logic [1:0] c);
        case (c)
            2'd0: return 16;
            2'd1: return 20;
            2'd2: return 24;
            default: return 32;
        endcase
    endfunction

    // scoreboard monitor: pops and compares every sample the block offers
    always @(negedge clk) begin
        if (mon_on && rd_valid_o) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R10 unexpected sample", rd_data_o, 32'h0);
            end else begin
                logic [31:0] e;
                e = expq.pop_front();
                chk(rd_data_o === e, "R3/R8 sample value", rd_data_o, e);
            end
            rd_pop_i = 1'b1;
        end else begin
            rd_pop_i = 1'b0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic drive_bit(input logic fs, input logic d);
        @(negedge clk);
        sclk_i  = sclk_fall_i;
        fsync_i = fs;
        sd_i    = {NP{~d}};
        sd_i[port_idx] = d;
        @(negedge clk);
        @(negedge clk);
        sclk_i = ~sclk_fall_i;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_frame(input int en_bit, input int dis_bit, input int lim, input bit exp_on);
        int ns, w, tot, idx, kept, pushed;
        logic [31:0] m, v;
        ns = int'(slots_m1_i) + 1;
        w  = wbits_of(width_sel_i);
        m  = wmask(w);
        kept = 0;
        pushed = 0;
        for (int s = 0; s < ns; s++) begin
            if (!slot_ignore_i[s] && kept < int'(nchans_i)) begin
                kept++;
                v = vals[s] & m;
                if (!no_fb_i && lpbk_i) v = m;
                if (exp_on && pushed < lim) begin
                    expq.push_back(v);
                    pushed++;
                end
            end
        end
        tot = int'(bit_start_i) + ns * w;
        idx = 0;
        if (bit_start_i) begin
            drive_bit(1'b1, 1'b0);
            idx = 1;
        end
        for (int s = 0; s < ns; s++) begin
            for (int k = 0; k < w; k++) begin
                logic b;
                b = lsb_first_i ? vals[s][k] : vals[s][w-1-k];
                if (idx == en_bit)  enable_i = 1'b1;
                if (idx == dis_bit) enable_i = 1'b0;
                drive_bit(idx < tot / 2, b);
                idx++;
            end
        end
    endtask

    task automatic drain(input string req);
        repeat (40) @(negedge clk);
        chk(expq.size() == 0, req, expq.size(), 0);
    endtask

    initial begin
        vals[0] = 32'h0000_A5C3; vals[1] = 32'h0000_1234;
        vals[2] = 32'h0000_8001; vals[3] = 32'h0000_7FFE;
        vals[4] = 32'h0000_0F0F; vals[5] = 32'h0000_C0DE;
        vals[6] = 32'h0000_BEEF; vals[7] = 32'h0000_0101;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R9, R10)
        chk(rd_valid_o == 1'b0, "R10 reset empty", rd_valid_o, 0);
        chk(overflow_o == 1'b0, "R10 reset overflow", overflow_o, 0);
        chk(rst_busy_o == 1'b0, "R9 reset busy", rst_busy_o, 0);

        // R3 R6 R8: 2 slots of 16 bits, one-bit delay, MSB first
        enable_i = 1'b1;
        send_frame(-1, -1, 99, 1'b1);
        send_frame(-1, -1, 99, 1'b1);
        drain("R6 16-bit frames");

        // R3: 4 slots of 20 bits
        slots_m1_i = 3'd3; width_sel_i = 2'd1;
        vals[0] = 32'hF_1234; vals[1] = 32'h8_0001; vals[2] = 32'h7_FFFF; vals[3] = 32'hA_5A5A;
        send_frame(-1, -1, 99, 1'b1);
        drain("R3 20-bit frame");

        // R4: LSB first, 3 slots of 24 bits
        slots_m1_i = 3'd2; width_sel_i = 2'd2; lsb_first_i = 1'b1;
        vals[0] = 32'h80_0001; vals[1] = 32'h12_3456; vals[2] = 32'hC0_FFEE;
        send_frame(-1, -1, 99, 1'b1);
        drain("R4 LSB-first frame");

        // R5 R6: falling-edge sampling, no delay, 32-bit slots
        lsb_first_i = 1'b0; sclk_fall_i = 1'b1; bit_start_i = 1'b0;
        slots_m1_i = 3'd1; width_sel_i = 2'd3;
        vals[0] = 32'hDEAD_BEEF; vals[1] = 32'h8000_0001;
        send_frame(-1, -1, 99, 1'b1);
        drain("R5 falling edge frame");

        // R1 R2: port 2 selected, loopback blocked
        sclk_fall_i = 1'b0; bit_start_i = 1'b1; width_sel_i = 2'd0;
        port_idx = 2; port_sel_i = 4'b0100; lpbk_i = 1'b1; no_fb_i = 1'b1;
        vals[0] = 32'h0000_3C3C; vals[1] = 32'h0000_0001;
        send_frame(-1, -1, 99, 1'b1);
        drain("R1 port select");

        // R2: loopback merged
        no_fb_i = 1'b0;
        send_frame(-1, -1, 99, 1'b1);
        drain("R2 loopback merged");
        lpbk_i = 1'b0;
        send_frame(-1, -1, 99, 1'b1);
        drain("R2 loopback idle");
        no_fb_i = 1'b1;

        // R7: ignore slots 0 and 2 of 6, keep lowest 2 of the rest (1, 3)
        slots_m1_i = 3'd5; slot_ignore_i = 8'b0000_0101; nchans_i = 4'd2;
        vals[0] = 32'h1111; vals[1] = 32'h2222; vals[2] = 32'h3333;
        vals[3] = 32'h4444; vals[4] = 32'h5555; vals[5] = 32'h6666;
        send_frame(-1, -1, 99, 1'b1);
        drain("R7 mask crop");
        slot_ignore_i = '0; nchans_i = 4'd8; slots_m1_i = 3'd1;

        // R11: enable during a frame, that frame is not captured
        enable_i = 1'b0;
        send_frame(5, -1, 99, 1'b0);
        send_frame(-1, -1, 99, 1'b1);
        drain("R11 partial frame");

        // R12: disable inside slot 0, nothing written
        send_frame(-1, 4, 99, 1'b0);
        repeat (8) @(negedge clk);
        chk(rd_valid_o == 1'b0, "R12 disabled frame", rd_valid_o, 0);
        enable_i = 1'b1;

        // R10: 8 slots into a 4-deep FIFO
        mon_on = 1'b0;
        slots_m1_i = 3'd7;
        vals[6] = 32'hAAAA; vals[7] = 32'h5555;
        send_frame(-1, -1, 4, 1'b1);
        repeat (4) @(negedge clk);
        chk(overflow_o == 1'b1, "R10 overflow set", overflow_o, 1);
        mon_on = 1'b1;
        drain("R10 order after overflow");
        chk(overflow_o == 1'b1, "R10 overflow sticky", overflow_o, 1);

        // R9: reset request clears FIFO and flag, busy for 3 cycles
        mon_on = 1'b0;
        slots_m1_i = 3'd1;
        send_frame(-1, -1, 99, 1'b0);
        repeat (4) @(negedge clk);
        chk(rd_valid_o == 1'b1, "R9 data before request", rd_valid_o, 1);
        rst_req_i = 1'b1;
        @(negedge clk);
        rst_req_i = 1'b0;
        chk(rst_busy_o == 1'b1, "R9 busy", rst_busy_o, 1);
        chk(rd_valid_o == 1'b0, "R9 fifo cleared", rd_valid_o, 0);
        chk(overflow_o == 1'b0, "R9 overflow cleared", overflow_o, 0);
        repeat (3) @(negedge clk);
        chk(rst_busy_o == 1'b0, "R9 busy self-clears", rst_busy_o, 0);
        mon_on = 1'b1;
        send_frame(-1, -1, 99, 1'b1);
        drain("R9 capture after request");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule